// File: doc/BRIEF.md
# Per-Part IO Bandwidth Counter Bank

This block observes the completed data transfers of one IO stack that joins a 16-lane serial link to an on-chip fabric, and accumulates bandwidth in four independent 48-bit counters. The link can be split into ports in four ways: one x16 port, two x8 ports, four x4 ports, or one x8 port plus two x4 ports. Each transfer carries the first lane of the port it came from. The block maps that lane to a "part", a 4-lane slice of the link, and discards any transfer whose lane is not the first lane of a port in the current split.

Each counter is set up through a small register interface. The setup picks a part, a traffic class (device read of memory, device write to memory, or CPU-initiated access) and an enable. An option lets device-class events also count peer-to-peer and address-remapped transfers. A counter advances by the transfer length in 4-byte units, wraps modulo its width, and keeps a sticky overflow bit. A global freeze bit holds all four counters so that software can read a consistent snapshot. A per-counter clear strobe zeroes the count and the overflow bit.

Top module: `io_bw_counters`

## Requirements
- R1: After reset every count, overflow bit, counter setup word and the freeze bit read as zero.
- R2: The split is set by `bif_mode`: 0 = one x16 port at lane 0; 1 = two x8 ports at lanes 0 and 8; 2 = four x4 ports at lanes 0, 4, 8 and 12; 3 = one x8 port at lane 0 plus x4 ports at lanes 8 and 12. A transfer's part is its lane divided by 4. A transfer whose lane is not the first lane of a port in the current mode changes no counter.
- R3: A counter set to a part with no port behind it in the current mode stays at zero whatever transfers arrive.
- R4: A counted transfer adds `xfer_len`/4 to the count. The new value is readable right after the clock edge that samples the transfer and not before it.
- R5: `xfer_kind` encodes 0 = device read of memory, 1 = device write to memory, 2 = CPU-initiated, 3 = not counted by any event. A counter counts only transfers whose kind equals its selected kind.
- R6: A transfer with `xfer_p2p` or `xfer_remap` set is never counted by a CPU-kind counter. It is counted by a device-kind counter only when that counter's all-targets bit is set.
- R7: All four counters may count the same transfer in the same cycle, each by the full increment.
- R8: A count wraps modulo 2^CNT_W, and the wrap sets the counter's overflow bit (bit 31 of its high readout word). The bit stays set until a clear.
- R9: Writing address 1 with data bit k set zeroes count k and its overflow bit on that clock edge. The clear wins over an increment in the same cycle and leaves the other counters unchanged.
- R10: Bit 0 at address 0 is the freeze bit. While it is set no count or overflow bit changes except through a clear.
- R11: Register map: address 8+k holds counter k's setup word (bit 0 enable, bits 2:1 part, bits 4:3 kind, bit 5 all-targets), readable as written. Address 16+2k returns count bits 31:0. Address 17+2k returns the overflow bit in bit 31 and count bits above 31 in the low bits. Reads are combinational from `reg_addr`. A counter whose enable bit is clear does not count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bif_mode | input | 2 | Static lane split of the link (R2 encoding) |
| xfer_valid | input | 1 | A completed transfer is present this cycle |
| xfer_lane | input | 4 | First lane of the transfer's port |
| xfer_len | input | 10 | Transfer length in bytes, a multiple of 4, at most 512 |
| xfer_kind | input | 2 | Traffic class (R5 encoding) |
| xfer_p2p | input | 1 | Transfer is peer-to-peer |
| xfer_remap | input | 1 | Transfer went through address remapping |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |

## Verification
A transfer or register write applied in one cycle acts on the next rising edge. Its effect on a count, an overflow bit, a setup word or the freeze bit is visible in `reg_rdata` right after that edge, because reads add no cycle. The bench drives each stimulus on a falling edge and removes it on the next falling edge. It then sets the read address and samples one nanosecond later, which is one register stage after the stimulus. For the timing requirement it also samples the count before the capturing edge, to show the value has not yet moved.

// File: rtl/iobw_pkg.sv
package iobw_pkg;

  localparam int PART_W = 2;

  typedef enum logic [1:0] {
    BIF_ONE_X16   = 2'd0,
    BIF_TWO_X8    = 2'd1,
    BIF_FOUR_X4   = 2'd2,
    BIF_X8_TWO_X4 = 2'd3
  } bif_e;

  typedef enum logic [1:0] {
    KIND_DEV_RD = 2'd0,
    KIND_DEV_WR = 2'd1,
    KIND_CPU    = 2'd2,
    KIND_NONE   = 2'd3
  } kind_e;

  // Setup word of one counter, bit 0 is the enable.
  typedef struct packed {
    logic              all_tgt;
    logic [1:0]        kind;
    logic [PART_W-1:0] part;
    logic              en;
  } ctr_cfg_t;

  localparam int CFG_W = $bits(ctr_cfg_t);

  // Transfer length in bytes to count units of four bytes.
  function automatic logic [9:0] bytes_to_units(input logic [9:0] len);
    return {2'b00, len[9:2]};
  endfunction

  // Whether an excluded-traffic flag keeps a transfer out of an event.
  function automatic logic traffic_excluded(input logic p2p, input logic rmp,
                                            input logic [1:0] kind,
                                            input logic all_tgt);
    return (p2p | rmp) & ((kind == KIND_CPU) | ~all_tgt);
  endfunction

endpackage

// File: rtl/iobw_port_decode.sv
module iobw_port_decode #(
  parameter int LANES          = 16,
  parameter int LANES_PER_PART = 4,
  localparam int NUM_PARTS     = LANES / LANES_PER_PART,
  localparam int LANE_W        = $clog2(LANES),
  localparam int SLICE_W       = $clog2(LANES_PER_PART),
  localparam int PART_IDX_W    = LANE_W - SLICE_W
) (
  input  logic                  valid,
  input  logic [1:0]            mode,
  input  logic [LANE_W-1:0]     lane,
  output logic                  accept,
  output logic [PART_IDX_W-1:0] part
);

  logic [NUM_PARTS-1:0] populated;
  logic                 aligned;

  // Parts with a port whose first lane lies in them, per split mode.
  function automatic logic [NUM_PARTS-1:0] parts_in_use(input logic [1:0] m);
    logic [NUM_PARTS-1:0] r;
    r = '0;
    for (int p = 0; p < NUM_PARTS; p++) begin
      unique case (m)
        iobw_pkg::BIF_ONE_X16:   r[p] = (p == 0);
        iobw_pkg::BIF_TWO_X8:    r[p] = (p == 0) || (p == NUM_PARTS / 2);
        iobw_pkg::BIF_FOUR_X4:   r[p] = 1'b1;
        iobw_pkg::BIF_X8_TWO_X4: r[p] = (p == 0) || (p >= NUM_PARTS / 2);
        default:                 r[p] = 1'b0;
      endcase
    end
    return r;
  endfunction

  assign populated = parts_in_use(mode);
  assign part      = lane[LANE_W-1:SLICE_W];
  assign aligned   = (lane[SLICE_W-1:0] == '0);
  assign accept    = valid && aligned && populated[part];

endmodule

// File: rtl/iobw_event_match.sv
module iobw_event_match (
  input  iobw_pkg::ctr_cfg_t        cfg,
  input  logic                      accept,
  input  logic [iobw_pkg::PART_W-1:0] part,
  input  logic [1:0]                kind,
  input  logic                      p2p,
  input  logic                      rmp,
  output logic                      hit
);

  logic part_ok;
  logic kind_ok;
  logic blocked;

  assign part_ok = (cfg.part == part);
  assign kind_ok = (cfg.kind == kind) && (kind != iobw_pkg::KIND_NONE);
  assign blocked = iobw_pkg::traffic_excluded(p2p, rmp, kind, cfg.all_tgt);
  assign hit     = accept && cfg.en && part_ok && kind_ok && !blocked;

endmodule

// File: rtl/iobw_counter.sv
module iobw_counter #(
  parameter int CNT_W = 48,
  parameter int INC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic [INC_W-1:0] inc,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf,
  output logic             wrap_evt
);

  logic [CNT_W:0] sum;

  assign sum      = {1'b0, cnt} + {{(CNT_W + 1 - INC_W){1'b0}}, inc};
  assign wrap_evt = step && sum[CNT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else if (clr) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else if (step) begin
      cnt <= sum[CNT_W-1:0];
      if (wrap_evt) ovf <= 1'b1;
    end
  end

endmodule

// File: rtl/io_bw_counters.sv
module io_bw_counters #(
  parameter int NUM_CTR        = 4,
  parameter int CNT_W          = 48,
  parameter int LANES          = 16,
  parameter int LANES_PER_PART = 4,
  parameter int LEN_W          = 10,
  parameter int ADDR_W         = 5,
  localparam int LANE_W        = $clog2(LANES),
  localparam int INC_W         = LEN_W - 2,
  localparam int PART_IDX_W    = LANE_W - $clog2(LANES_PER_PART)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bif_mode,
  input  logic              xfer_valid,
  input  logic [LANE_W-1:0] xfer_lane,
  input  logic [LEN_W-1:0]  xfer_len,
  input  logic [1:0]        xfer_kind,
  input  logic              xfer_p2p,
  input  logic              xfer_remap,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata
);

  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(1);
  localparam int A_CFG_BASE = 8;
  localparam int A_CNT_BASE = 16;

  // Named internal events, used by the bound checker.
  logic                              freeze_q;
  logic                              xfer_accept;
  logic [PART_IDX_W-1:0]             xfer_part;
  logic [INC_W-1:0]                  inc_val;
  logic [NUM_CTR-1:0]                clr_pulse;
  logic [NUM_CTR-1:0]                ctr_hit;
  logic [NUM_CTR-1:0]                inc_en;
  logic [NUM_CTR-1:0]                ctr_ovf;
  logic [NUM_CTR-1:0]                ctr_wrap;
  logic [NUM_CTR-1:0][CNT_W-1:0]     ctr_cnt;
  iobw_pkg::ctr_cfg_t                cfg_q [NUM_CTR];
  logic [LEN_W-1:0]                  len_units;

  // Transfer front end.
  iobw_port_decode #(
    .LANES         (LANES),
    .LANES_PER_PART(LANES_PER_PART)
  ) u_decode (
    .valid (xfer_valid),
    .mode  (bif_mode),
    .lane  (xfer_lane),
    .accept(xfer_accept),
    .part  (xfer_part)
  );

  assign len_units = LEN_W'(iobw_pkg::bytes_to_units(10'(xfer_len)));
  assign inc_val   = len_units[INC_W-1:0];

  // Control register: freeze.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              freeze_q <= 1'b0;
    else if (reg_we && reg_addr == A_CTL)    freeze_q <= reg_wdata[0];
  end

  // Counter slices.
  for (genvar k = 0; k < NUM_CTR; k++) begin : g_ctr
    localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(A_CFG_BASE + k);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            cfg_q[k] <= '0;
      else if (reg_we && reg_addr == A_CFG)  cfg_q[k] <= iobw_pkg::ctr_cfg_t'(reg_wdata[iobw_pkg::CFG_W-1:0]);
    end

    assign clr_pulse[k] = reg_we && (reg_addr == A_CLR) && reg_wdata[k];

    iobw_event_match u_match (
      .cfg   (cfg_q[k]),
      .accept(xfer_accept),
      .part  (iobw_pkg::PART_W'(xfer_part)),
      .kind  (xfer_kind),
      .p2p   (xfer_p2p),
      .rmp   (xfer_remap),
      .hit   (ctr_hit[k])
    );

    assign inc_en[k] = ctr_hit[k] && !freeze_q;

    iobw_counter #(
      .CNT_W(CNT_W),
      .INC_W(INC_W)
    ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr_pulse[k]),
      .step    (inc_en[k]),
      .inc     (inc_val),
      .cnt     (ctr_cnt[k]),
      .ovf     (ctr_ovf[k]),
      .wrap_evt(ctr_wrap[k])
    );
  end

  // Count zero-extended to 63 bits, split into two readout words.
  function automatic logic [62:0] pad_count(input logic [CNT_W-1:0] c);
    return 63'(c);
  endfunction

  always_comb begin
    logic [62:0] padded;
    reg_rdata = '0;
    padded    = '0;
    if (reg_addr == A_CTL) reg_rdata[0] = freeze_q;
    for (int k = 0; k < NUM_CTR; k++) begin
      padded = pad_count(ctr_cnt[k]);
      if (reg_addr == ADDR_W'(A_CFG_BASE + k))
        reg_rdata = 32'(cfg_q[k]);
      if (reg_addr == ADDR_W'(A_CNT_BASE + 2 * k))
        reg_rdata = padded[31:0];
      if (reg_addr == ADDR_W'(A_CNT_BASE + 2 * k + 1))
        reg_rdata = {ctr_ovf[k], padded[62:32]};
    end
  end

endmodule

// File: rtl/iobw_checker.sv
module iobw_checker #(
  parameter int NUM_CTR    = 4,
  parameter int CNT_W      = 48,
  parameter int INC_W      = 8,
  parameter int PART_IDX_W = 2
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [1:0]                    bif_mode,
  input logic [1:0]                    xfer_kind,
  input logic                          xfer_p2p,
  input logic                          xfer_remap,
  input logic                          freeze_q,
  input logic                          xfer_accept,
  input logic [PART_IDX_W-1:0]         xfer_part,
  input logic [INC_W-1:0]              inc_val,
  input logic [NUM_CTR-1:0]            clr_pulse,
  input logic [NUM_CTR-1:0]            inc_en,
  input logic [NUM_CTR-1:0]            ctr_ovf,
  input logic [NUM_CTR-1:0][CNT_W-1:0] ctr_cnt
);

  localparam int HALF = (1 << PART_IDX_W) / 2;

  logic part_has_port;
  always_comb begin
    part_has_port = (xfer_part == '0) || (bif_mode == 2'd2) ||
                    (bif_mode == 2'd1 && int'(xfer_part) == HALF) ||
                    (bif_mode == 2'd3 && int'(xfer_part) >= HALF);
  end

  p_accept_populated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_accept |-> part_has_port);

  for (genvar k = 0; k < NUM_CTR; k++) begin : g_chk
    p_reset_zero_r1: assert property (@(posedge clk)
      !rst_n |=> (ctr_cnt[k] == '0 && !ctr_ovf[k]));

    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_en[k] && !clr_pulse[k]) |=>
        ctr_cnt[k] == CNT_W'($past(ctr_cnt[k]) + CNT_W'($past(inc_val))));

    p_excluded_cpu_r6: assert property (@(posedge clk) disable iff (!rst_n)
      inc_en[k] |-> !(xfer_kind == 2'd2 && (xfer_p2p || xfer_remap)));

    p_count_needs_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      inc_en[k] |-> xfer_accept);

    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctr_ovf[k] && !clr_pulse[k]) |=> ctr_ovf[k]);

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr_pulse[k] |=> (ctr_cnt[k] == '0 && !ctr_ovf[k]));

    p_freeze_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze_q && !clr_pulse[k]) |=> ($stable(ctr_cnt[k]) && $stable(ctr_ovf[k])));
  end

endmodule

bind io_bw_counters iobw_checker #(
  .NUM_CTR   (NUM_CTR),
  .CNT_W     (CNT_W),
  .INC_W     (INC_W),
  .PART_IDX_W(PART_IDX_W)
) u_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .bif_mode   (bif_mode),
  .xfer_kind  (xfer_kind),
  .xfer_p2p   (xfer_p2p),
  .xfer_remap (xfer_remap),
  .freeze_q   (freeze_q),
  .xfer_accept(xfer_accept),
  .xfer_part  (xfer_part),
  .inc_val    (inc_val),
  .clr_pulse  (clr_pulse),
  .inc_en     (inc_en),
  .ctr_ovf    (ctr_ovf),
  .ctr_cnt    (ctr_cnt)
);

// File: tb/test_io_bw_counters.sv
`timescale 1ns/1ps
module test_io_bw_counters;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bif_mode = 2'd2;
  logic        xfer_valid = 1'b0;
  logic [3:0]  xfer_lane = '0;
  logic [9:0]  xfer_len = '0;
  logic [1:0]  xfer_kind = '0;
  logic        xfer_p2p = 1'b0;
  logic        xfer_remap = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rdata_main;
  logic [31:0] rdata_small;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  io_bw_counters i_io_bw_counters (
    .clk(clk), .rst_n(rst_n), .bif_mode(bif_mode), .xfer_valid(xfer_valid),
    .xfer_lane(xfer_lane), .xfer_len(xfer_len), .xfer_kind(xfer_kind),
    .xfer_p2p(xfer_p2p), .xfer_remap(xfer_remap), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_main)
  );

  // Narrow copy used only to reach the wrap point quickly.
  io_bw_counters #(.CNT_W(10)) i_io_bw_counters_wrap (
    .clk(clk), .rst_n(rst_n), .bif_mode(bif_mode), .xfer_valid(xfer_valid),
    .xfer_lane(xfer_lane), .xfer_len(xfer_len), .xfer_kind(xfer_kind),
    .xfer_p2p(xfer_p2p), .xfer_remap(xfer_remap), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_small)
  );

  typedef struct packed {
    logic [1:0] mode;
    logic [3:0] lane;
    logic [9:0] len;
    logic [1:0] kind;
    logic       p2p;
    logic       rmp;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{2'd2, 4'd0,  10'd64,  2'd0, 1'b0, 1'b0},
    '{2'd2, 4'd4,  10'd128, 2'd2, 1'b0, 1'b0},
    '{2'd2, 4'd8,  10'd512, 2'd1, 1'b0, 1'b0},
    '{2'd2, 4'd12, 10'd256, 2'd0, 1'b0, 1'b0},
    '{2'd2, 4'd12, 10'd40,  2'd0, 1'b1, 1'b0},
    '{2'd2, 4'd0,  10'd100, 2'd0, 1'b0, 1'b1},
    '{2'd2, 4'd4,  10'd32,  2'd2, 1'b1, 1'b0},
    '{2'd1, 4'd8,  10'd16,  2'd1, 1'b0, 1'b1},
    '{2'd1, 4'd4,  10'd64,  2'd2, 1'b0, 1'b0},
    '{2'd3, 4'd12, 10'd8,   2'd0, 1'b0, 1'b0},
    '{2'd3, 4'd4,  10'd8,   2'd2, 1'b0, 1'b0},
    '{2'd0, 4'd8,  10'd16,  2'd1, 1'b0, 1'b0},
    '{2'd0, 4'd0,  10'd508, 2'd0, 1'b0, 1'b0},
    '{2'd2, 4'd0,  10'd64,  2'd3, 1'b0, 1'b0},
    '{2'd2, 4'd5,  10'd64,  2'd0, 1'b0, 1'b0}
  };

  // Setup words: {all, kind[1:0], part[1:0], en}.
  localparam logic [5:0] CFG [4] = '{6'h01, 6'h2D, 6'h13, 6'h27};

  // Bench model of the requirements.
  function automatic bit port_start(input logic [1:0] m, input logic [3:0] ln);
    case (m)
      2'd0:    return ln == 0;
      2'd1:    return ln == 0 || ln == 8;
      2'd2:    return ln inside {0, 4, 8, 12};
      default: return ln == 0 || ln == 8 || ln == 12;
    endcase
  endfunction

  function automatic int model_add(input vec_t v, input logic [5:0] c);
    bit en  = c[0];
    int prt = int'(c[2:1]);
    int knd = int'(c[4:3]);
    bit all = c[5];
    if (!en || !port_start(v.mode, v.lane)) return 0;
    if (int'(v.lane) / 4 != prt) return 0;
    if (int'(v.kind) != knd || v.kind == 2'd3) return 0;
    if (v.p2p || v.rmp) begin
      if (v.kind == 2'd2) return 0;
      if (!all) return 0;
    end
    return int'(v.len) / 4;
  endfunction

  task automatic check(input string tag, input longint got, input longint exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] m, output logic [31:0] s);
    @(negedge clk);
    reg_addr = a;
    #1;
    m = rdata_main;
    s = rdata_small;
  endtask

  task automatic send(input logic [1:0] m, input logic [3:0] ln, input logic [9:0] len,
                      input logic [1:0] k, input logic p, input logic r);
    @(negedge clk);
    bif_mode = m; xfer_lane = ln; xfer_len = len; xfer_kind = k;
    xfer_p2p = p; xfer_remap = r; xfer_valid = 1'b1;
    @(negedge clk);
    xfer_valid = 1'b0;
  endtask

  task automatic chk_cnt(input string tag, input int k, input longint exp);
    logic [31:0] m, s;
    rd(5'(16 + 2 * k), m, s);
    check(tag, longint'(m), exp);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [31:0] m, s;
    longint exp [4];

    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd(5'd0, m, s);  check("R1 freeze", m, 0);
    for (int k = 0; k < 4; k++) begin
      rd(5'(8 + k), m, s);       check("R1 setup", m, 0);
      rd(5'(16 + 2 * k), m, s);  check("R1 count lo", m, 0);
      rd(5'(17 + 2 * k), m, s);  check("R1 count hi", m, 0);
    end

    // R11: setup words read back
    for (int k = 0; k < 4; k++) wr(5'(8 + k), 32'(CFG[k]));
    for (int k = 0; k < 4; k++) begin
      rd(5'(8 + k), m, s);  check("R11 setup readback", m, longint'(CFG[k]));
    end

    // R2 R4 R5 R6: table walk against the bench model
    for (int k = 0; k < 4; k++) exp[k] = 0;
    for (int i = 0; i < NV; i++) begin
      send(VECS[i].mode, VECS[i].lane, VECS[i].len, VECS[i].kind, VECS[i].p2p, VECS[i].rmp);
      for (int k = 0; k < 4; k++) begin
        exp[k] += model_add(VECS[i], CFG[k]);
        chk_cnt($sformatf("R2/R4/R5/R6 vec%0d ctr%0d", i, k), k, exp[k]);
      end
    end

    // R4: value moves only at the capturing edge
    wr(5'd1, 32'hF);
    @(negedge clk);
    bif_mode = 2'd2; xfer_lane = 4'd0; xfer_len = 10'd64; xfer_kind = 2'd0;
    xfer_p2p = 1'b0; xfer_remap = 1'b0; xfer_valid = 1'b1; reg_addr = 5'd16;
    #1; check("R4 before edge", rdata_main, 0);
    @(negedge clk);
    xfer_valid = 1'b0;
    #1; check("R4 after edge", rdata_main, 16);

    // R3: unpopulated parts stay at zero
    wr(5'd9, 32'h03);   // part 1, device read
    wr(5'd10, 32'h07);  // part 3, device read
    wr(5'd1, 32'hF);
    send(2'd0, 4'd4, 10'd64, 2'd0, 1'b0, 1'b0);
    send(2'd1, 4'd4, 10'd64, 2'd0, 1'b0, 1'b0);
    send(2'd1, 4'd12, 10'd64, 2'd0, 1'b0, 1'b0);
    send(2'd0, 4'd12, 10'd64, 2'd0, 1'b0, 1'b0);
    chk_cnt("R3 part1 in x16/x8", 1, 0);
    chk_cnt("R3 part3 in x16/x8", 2, 0);
    send(2'd2, 4'd4, 10'd64, 2'd0, 1'b0, 1'b0);
    chk_cnt("R3 part1 populated in x4", 1, 16);

    // R7: all four counters on one transfer; R11 enable bit
    for (int k = 0; k < 4; k++) wr(5'(8 + k), 32'h21);
    wr(5'd1, 32'hF);
    send(2'd2, 4'd0, 10'd256, 2'd0, 1'b1, 1'b0);
    for (int k = 0; k < 4; k++) chk_cnt("R7 concurrent", k, 64);
    wr(5'd11, 32'h20);
    send(2'd2, 4'd0, 10'd256, 2'd0, 1'b0, 1'b0);
    chk_cnt("R11 enabled counts", 0, 128);
    chk_cnt("R11 disabled holds", 3, 64);

    // R10: freeze holds, clear still acts
    wr(5'd0, 32'h1);
    rd(5'd0, m, s); check("R10 freeze bit", m, 1);
    send(2'd2, 4'd0, 10'd256, 2'd0, 1'b0, 1'b0);
    chk_cnt("R10 frozen ctr0", 0, 128);
    chk_cnt("R10 frozen ctr2", 2, 128);
    wr(5'd1, 32'h2);
    chk_cnt("R10 clear under freeze", 1, 0);
    wr(5'd0, 32'h0);
    send(2'd2, 4'd0, 10'd256, 2'd0, 1'b0, 1'b0);
    chk_cnt("R10 thawed", 0, 192);

    // R9: clear beats a same-cycle increment, others unaffected
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 5'd1; reg_wdata = 32'h1;
    bif_mode = 2'd2; xfer_lane = 4'd0; xfer_len = 10'd256; xfer_kind = 2'd0;
    xfer_p2p = 1'b0; xfer_remap = 1'b0; xfer_valid = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; xfer_valid = 1'b0;
    chk_cnt("R9 cleared ctr0", 0, 0);
    chk_cnt("R9 ctr1 kept", 1, 128);
    chk_cnt("R9 ctr2 kept", 2, 256);

    // R8: wrap on the 10-bit copy, sticky overflow
    wr(5'd8, 32'h01);
    wr(5'd1, 32'hF);
    for (int i = 0; i < 7; i++) send(2'd2, 4'd0, 10'd512, 2'd0, 1'b0, 1'b0);
    rd(5'd16, m, s); check("R8 before wrap lo", s, 896);
    rd(5'd17, m, s); check("R8 before wrap ovf", s[31], 0);
    for (int i = 0; i < 2; i++) send(2'd2, 4'd0, 10'd512, 2'd0, 1'b0, 1'b0);
    rd(5'd16, m, s); check("R8 wrapped lo", s, 128);
    check("R8 wide counter lo", m, 1152);
    rd(5'd17, m, s); check("R8 ovf set", s[31], 1);
    check("R8 wide counter no ovf", m, 0);
    send(2'd2, 4'd0, 10'd4, 2'd0, 1'b0, 1'b0);
    rd(5'd17, m, s); check("R8 ovf sticky", s[31], 1);
    wr(5'd1, 32'h1);
    rd(5'd17, m, s); check("R9 ovf cleared", s, 0);
    rd(5'd16, m, s); check("R9 count cleared", s, 0);

    done = 1'b1;
    summary();
  end

endmodule